// File: doc/BRIEF.md
# I/O-Page Soft-Switch Controller

This block sits on a 16-bit CPU bus and decodes a small set of addresses inside the I/O page (upper address byte 0xC0). Touching one of these addresses, by a read or by a write, is itself the command. Paired set/clear addresses drive four single-bit mode flags: text display, mixed display, high-resolution display and the upper slot-ROM mapping. The value on the data bus does not matter for these switches. The block also keeps a latched keyboard byte whose bit 7 is a pending-key strobe. That strobe is cleared as a side effect of accessing a dedicated address.

Status addresses return a byte that carries a flag in bit 7 above a fixed low pattern of 0x0D. Any address outside the decoded set drops `hit` and returns 0x00, so other bus devices can answer it. Every action happens once per access. An access starts on the clock edge where a bus strobe is first seen high, and a strobe held for several cycles still counts as one access. Keyboard codes arrive as a single-cycle `key_press` pulse. The block accepts a key on every cycle, so the keyboard path has no back-pressure. A new key overwrites any key that is still pending.

Top module: `sswitch_ctrl`

## Requirements
- R1: An access, read or write, to 0xC050 clears `text_mode` and one to 0xC051 sets it. The data value is ignored, `hit` is 1 and `rd_data` is 0x00.
- R2: By the same access rule, 0xC052/0xC053 clear/set `mixed_mode` and 0xC056/0xC057 clear/set `hires_mode`. Each of these accesses gives `hit` = 1 and `rd_data` = 0x00.
- R3: After reset `text_mode` = 1, `mixed_mode` = `hires_mode` = `slot_rom_hi` = 0, `hit` = 0, `rd_data` = 0x00, and the keyboard byte is 0x00.
- R4: A `key_press` pulse loads the keyboard byte with {1, `key_code[6:0]`}. A read of 0xC000 returns that byte, with the strobe in bit 7.
- R5: A read or a write of 0xC010 clears bit 7 of the keyboard byte and leaves bits 6:0 unchanged. A read of 0xC010 returns the byte as it was before the clear.
- R6: When a `key_press` falls in the same cycle as a strobe clear, the key wins: the byte holds the new code with bit 7 set.
- R7: A write to 0xC007 sets `slot_rom_hi` and a write to 0xC006 clears it, with `hit` = 1. A read of either address changes nothing and returns `hit` = 0.
- R8: A read of 0xC015 returns 0x8D when `slot_rom_hi` is 1 and 0x0D when it is 0.
- R9: Reads of 0xC018, 0xC01C, 0xC01E and 0xC01F return 0x0D with `hit` = 1.
- R10: An access to an undecoded address gives `hit` = 0 and `rd_data` = 0x00, and changes no flag.
- R11: Flags, `hit` and `rd_data` update at the clock edge where a strobe is first sampled high. They hold until the next access, and a held strobe counts as a single access even if the address changes while it is held.
- R12: If read and write strobes start in the same cycle, the access is a read. Any write access returns `rd_data` = 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | Read strobe (level; rising edge starts an access) |
| bus_wr | input | 1 | Write strobe (level; rising edge starts an access) |
| bus_wdata | input | 8 | Write data (ignored by every switch) |
| key_code | input | 8 | Keyboard code; bits 6:0 are used |
| key_press | input | 1 | One-cycle pulse loading `key_code` |
| rd_data | output | 8 | Read result of the last access |
| hit | output | 1 | Last access matched a decoded address |
| text_mode | output | 1 | Text display flag |
| mixed_mode | output | 1 | Mixed display flag |
| hires_mode | output | 1 | High-resolution flag |
| slot_rom_hi | output | 1 | Upper slot-ROM mapping selected |

## Verification
The keyboard latch can receive a new key and a strobe clear in the same cycle. The bench provokes this by pulsing `key_press` on the very cycle a read of 0xC010 starts. It then judges two things: the read must return the old byte, with bit 7 as it was, and a later read of 0xC000 must show the new code with bit 7 set. The bench also starts read and write together on 0xC015 to check that the read decode wins.

// File: rtl/sswitch_pkg.sv
package sswitch_pkg;

  localparam int FLAG_N    = 4;
  localparam int FLAG_IW   = $clog2(FLAG_N);
  localparam int FL_TEXT   = 0;
  localparam int FL_MIXED  = 1;
  localparam int FL_HIRES  = 2;
  localparam int FL_ROM    = 3;

  localparam logic [7:0] STAT_LOW = 8'h0D;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_KBD_DATA,
    OP_KBD_CLR,
    OP_FLAG,
    OP_ROM_STAT,
    OP_FIXED
  } sw_op_e;

  typedef struct packed {
    logic               hit;
    sw_op_e             op;
    logic [FLAG_IW-1:0] flag_idx;
    logic               flag_val;
  } sw_dec_t;

endpackage

// File: rtl/sw_strobe_edge.sv
module sw_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  input  logic wr,
  output logic acc,
  output logic acc_is_read
);
  logic rd_q, wr_q;
  logic rd_start, wr_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd;
      wr_q <= wr;
    end
  end

  assign rd_start    = rd & ~rd_q;
  assign wr_start    = wr & ~wr_q;
  assign acc         = rd_start | wr_start;
  assign acc_is_read = rd_start;
endmodule

// File: rtl/sw_decode.sv
module sw_decode
  import sswitch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-9:0] PAGE = 'hC0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_read,
  output sw_dec_t           dec
);
  logic in_page;
  assign in_page = (addr[ADDR_W-1:8] == PAGE);

  always_comb begin
    dec = '{hit: 1'b0, op: OP_NONE, flag_idx: '0, flag_val: 1'b0};
    if (in_page) begin
      unique case (addr[7:0])
        8'h00: if (is_read) begin
          dec.hit = 1'b1; dec.op = OP_KBD_DATA;
        end
        8'h10: begin
          dec.hit = 1'b1; dec.op = OP_KBD_CLR;
        end
        8'h06, 8'h07: if (!is_read) begin
          dec.hit      = 1'b1;
          dec.op       = OP_FLAG;
          dec.flag_idx = FLAG_IW'(FL_ROM);
          dec.flag_val = addr[0];
        end
        8'h15: if (is_read) begin
          dec.hit = 1'b1; dec.op = OP_ROM_STAT;
        end
        8'h18, 8'h1C, 8'h1E, 8'h1F: if (is_read) begin
          dec.hit = 1'b1; dec.op = OP_FIXED;
        end
        8'h50, 8'h51: begin
          dec.hit = 1'b1; dec.op = OP_FLAG;
          dec.flag_idx = FLAG_IW'(FL_TEXT);  dec.flag_val = addr[0];
        end
        8'h52, 8'h53: begin
          dec.hit = 1'b1; dec.op = OP_FLAG;
          dec.flag_idx = FLAG_IW'(FL_MIXED); dec.flag_val = addr[0];
        end
        8'h56, 8'h57: begin
          dec.hit = 1'b1; dec.op = OP_FLAG;
          dec.flag_idx = FLAG_IW'(FL_HIRES); dec.flag_val = addr[0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sw_flag_bank.sv
module sw_flag_bank #(
  parameter int N = 4,
  parameter logic [N-1:0] RESET_VAL = '0,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic          val,
  output logic [N-1:0]  flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        flags[i] <= RESET_VAL[i];
      else if (we && (idx == IW'(i)))
        flags[i] <= val;
    end
  end
endmodule

// File: rtl/sw_kbd_latch.sv
module sw_kbd_latch #(
  parameter int DATA_W = 8,
  localparam int CODE_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              press,
  input  logic [CODE_W-1:0] code,
  input  logic              clr,
  output logic [DATA_W-1:0] kbyte
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      kbyte <= '0;
    else if (press)
      kbyte <= {1'b1, code};
    else if (clr)
      kbyte[DATA_W-1] <= 1'b0;
  end
endmodule

// File: rtl/sswitch_ctrl.sv
module sswitch_ctrl
  import sswitch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] key_code,
  input  logic              key_press,
  output logic [DATA_W-1:0] rd_data,
  output logic              hit,
  output logic              text_mode,
  output logic              mixed_mode,
  output logic              hires_mode,
  output logic              slot_rom_hi
);
  localparam logic [FLAG_N-1:0] FLAG_RST = FLAG_N'(1) << FL_TEXT;

  logic              acc, acc_rd;
  sw_dec_t           dec;
  logic [FLAG_N-1:0] flags;
  logic [DATA_W-1:0] kbyte;
  logic [DATA_W-1:0] rd_next;
  logic              unused_in;

  assign unused_in = ^{bus_wdata, key_code[DATA_W-1]};

  sw_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .wr(bus_wr),
    .acc(acc), .acc_is_read(acc_rd)
  );

  sw_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .is_read(acc_rd), .dec(dec)
  );

  sw_flag_bank #(.N(FLAG_N), .RESET_VAL(FLAG_RST)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .we(acc && dec.op == OP_FLAG),
    .idx(dec.flag_idx), .val(dec.flag_val),
    .flags(flags)
  );

  sw_kbd_latch #(.DATA_W(DATA_W)) u_kbd (
    .clk(clk), .rst_n(rst_n),
    .press(key_press), .code(key_code[DATA_W-2:0]),
    .clr(acc && dec.op == OP_KBD_CLR),
    .kbyte(kbyte)
  );

  always_comb begin
    rd_next = '0;
    if (acc_rd) begin
      unique case (dec.op)
        OP_KBD_DATA, OP_KBD_CLR: rd_next = kbyte;
        OP_ROM_STAT: rd_next = DATA_W'({flags[FL_ROM], STAT_LOW[6:0]});
        OP_FIXED:    rd_next = DATA_W'(STAT_LOW);
        default:     rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      hit     <= 1'b0;
    end else if (acc) begin
      rd_data <= rd_next;
      hit     <= dec.hit;
    end
  end

  assign text_mode   = flags[FL_TEXT];
  assign mixed_mode  = flags[FL_MIXED];
  assign hires_mode  = flags[FL_HIRES];
  assign slot_rom_hi = flags[FL_ROM];
endmodule

// File: rtl/sswitch_ctrl_chk.sv
module sswitch_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  rd_data,
  input logic        hit,
  input logic        text_mode,
  input logic        mixed_mode,
  input logic        hires_mode,
  input logic        slot_rom_hi
);
  logic rd_d, wr_d, acc_c, rds_c;
  always_ff @(posedge clk) begin
    if (!rst_n) begin rd_d <= 1'b0; wr_d <= 1'b0; end
    else begin rd_d <= bus_rd; wr_d <= bus_wr; end
  end
  assign rds_c = bus_rd && !rd_d;
  assign acc_c = rds_c || (bus_wr && !wr_d);

  AST_TEXT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && bus_addr == 16'hC051) |=> (text_mode && hit && rd_data == 8'h00)); // R1
  AST_HIRES_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && bus_addr == 16'hC056) |=> !hires_mode); // R2
  AST_ROM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rds_c && bus_addr == 16'hC015) |=> rd_data == ($past(slot_rom_hi) ? 8'h8D : 8'h0D)); // R8
  AST_OFF_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && bus_addr[15:8] != 8'hC0) |=> (!hit && rd_data == 8'h00 &&
      $stable({text_mode, mixed_mode, hires_mode, slot_rom_hi}))); // R10
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_c |=> $stable({text_mode, mixed_mode, hires_mode, slot_rom_hi, hit, rd_data})); // R11
endmodule

bind sswitch_ctrl sswitch_ctrl_chk u_chk (.*);

// File: tb/sswitch_ctrl_tb.sv
module sswitch_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0, key_press = 0;
  logic [7:0] bus_wdata = '0, key_code = '0;
  logic [7:0] rd_data;
  logic hit, text_mode, mixed_mode, hires_mode, slot_rom_hi;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sswitch_ctrl u_dut (.*);

  // fields: req[41:38] wr[37] addr[36:21] data[20:13] flags{rom,hires,mixed,text}[12:9] hit[8] rd[7:0]
  localparam logic [41:0] VEC [NVEC] = '{
    {4'd1,  1'b0, 16'hC050, 8'h00, 4'b0000, 1'b1, 8'h00}, // R1 read clears
    {4'd1,  1'b1, 16'hC051, 8'hFF, 4'b0001, 1'b1, 8'h00}, // R1 write sets
    {4'd2,  1'b0, 16'hC053, 8'h00, 4'b0011, 1'b1, 8'h00}, // R2
    {4'd2,  1'b1, 16'hC057, 8'h00, 4'b0111, 1'b1, 8'h00}, // R2
    {4'd2,  1'b0, 16'hC056, 8'h00, 4'b0011, 1'b1, 8'h00}, // R2
    {4'd2,  1'b1, 16'hC052, 8'h5A, 4'b0001, 1'b1, 8'h00}, // R2
    {4'd7,  1'b1, 16'hC007, 8'h00, 4'b1001, 1'b1, 8'h00}, // R7
    {4'd8,  1'b0, 16'hC015, 8'h00, 4'b1001, 1'b1, 8'h8D}, // R8
    {4'd7,  1'b1, 16'hC006, 8'h00, 4'b0001, 1'b1, 8'h00}, // R7
    {4'd8,  1'b0, 16'hC015, 8'h00, 4'b0001, 1'b1, 8'h0D}, // R8
    {4'd7,  1'b0, 16'hC007, 8'h00, 4'b0001, 1'b0, 8'h00}, // R7 read ignored
    {4'd9,  1'b0, 16'hC018, 8'h00, 4'b0001, 1'b1, 8'h0D}, // R9
    {4'd9,  1'b0, 16'hC01C, 8'h00, 4'b0001, 1'b1, 8'h0D}, // R9
    {4'd9,  1'b0, 16'hC01E, 8'h00, 4'b0001, 1'b1, 8'h0D}, // R9
    {4'd9,  1'b0, 16'hC01F, 8'h00, 4'b0001, 1'b1, 8'h0D}, // R9
    {4'd10, 1'b0, 16'h1234, 8'h00, 4'b0001, 1'b0, 8'h00}, // R10
    {4'd10, 1'b1, 16'hC0FF, 8'h00, 4'b0001, 1'b0, 8'h00}, // R10
    {4'd4,  1'b0, 16'hC000, 8'h00, 4'b0001, 1'b1, 8'h00}  // R4 no key yet
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] outs();
    return {3'b0, slot_rom_hi, hires_mode, mixed_mode, text_mode, hit, rd_data};
  endfunction

  // one access: strobe high for one cycle, outputs checked after the edge
  task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = !wr; bus_wr = wr;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
  endtask

  task automatic press(input logic [7:0] c);
    @(negedge clk);
    key_code = c; key_press = 1;
    @(negedge clk);
    key_press = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset outputs", outs(), {3'b0, 4'b0001, 1'b0, 8'h00});
    access(0, 16'hC000, 0);
    chk("R3 reset key byte", {8'h0, rd_data}, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][37], VEC[i][36:21], VEC[i][20:13]);
      chk($sformatf("R%0d vec%0d", VEC[i][41:38], i), outs(),
          {3'b0, VEC[i][12:9], VEC[i][8], VEC[i][7:0]});
    end

    // R4 key load
    press(8'h41);
    access(0, 16'hC000, 0);
    chk("R4 key byte", {8'h0, rd_data}, 16'h00C1);
    // R5 read clear returns old byte, then bit 7 gone
    access(0, 16'hC010, 0);
    chk("R5 clear read value", {7'h0, hit, rd_data}, 16'h01C1);
    access(0, 16'hC000, 0);
    chk("R5 after read clear", {8'h0, rd_data}, 16'h0041);
    press(8'hC2);
    access(1, 16'hC010, 0);
    chk("R5 write clear rd_data", {7'h0, hit, rd_data}, 16'h0100);
    access(0, 16'hC000, 0);
    chk("R5 after write clear", {8'h0, rd_data}, 16'h0042);

    // R6 key press in the same cycle as a strobe clear
    @(negedge clk);
    bus_addr = 16'hC010; bus_rd = 1; key_code = 8'h43; key_press = 1;
    @(negedge clk);
    bus_rd = 0; key_press = 0;
    chk("R6 clear read old byte", {8'h0, rd_data}, 16'h0042);
    access(0, 16'hC000, 0);
    chk("R6 new key kept", {8'h0, rd_data}, 16'h00C3);

    // R11 held strobe is one access, address change ignored while held
    @(negedge clk);
    bus_addr = 16'hC050; bus_rd = 1;
    @(negedge clk);
    chk("R11 first edge", {15'h0, text_mode}, 16'h0000);
    bus_addr = 16'hC051;
    repeat (3) @(negedge clk);
    chk("R11 held strobe", {15'h0, text_mode}, 16'h0000);
    bus_rd = 0;
    access(0, 16'hC01C, 0);
    repeat (4) @(negedge clk);
    chk("R11 rd_data holds", {7'h0, hit, rd_data}, 16'h010D);
    access(0, 16'hC051, 0);
    chk("R11 fresh access", {15'h0, text_mode}, 16'h0001);

    // R12 read and write start together: read wins
    access(1, 16'hC007, 0);
    @(negedge clk);
    bus_addr = 16'hC015; bus_rd = 1; bus_wr = 1;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    chk("R12 simultaneous is read", {7'h0, hit, rd_data}, 16'h018D);
    access(1, 16'hC015, 0);
    chk("R12 write to status addr", {7'h0, hit, rd_data}, 16'h0000);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule